// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block moves bytes between peripherals and memory on behalf of a processor. Each of four
channels keeps a programmed base address and base count, working copies of both, and a small
mode word. A peripheral asks for service on its request line, or software sets a request bit.
The engine then raises a bus hold request and waits for the arbiter's acknowledge. Once it has
the bus, it drives the working address, a memory read or memory write strobe and a one-hot
acknowledge to the served device. One byte moves per clock. After each byte it steps the address
up or down and decrements the count.

A channel is set up through a plain write port that carries a channel number, a field select and
the write data. The mode word picks one of three ways to end a service. Single gives one byte per
bus ownership. Block keeps the bus until terminal count or an end-of-process pulse. Demand also
stops when the request line drops. Terminal count happens on the byte where the count wraps from
zero to all-ones. At that point the channel either reloads its base values (autoinitialize) or
stops until its count is written again. Completion sets a per-channel interrupt flag, and the
flags are ORed onto one interrupt pin. There is no data stream at the boundary, only strobes, so
every pin is a plain control or status signal.

Top module: `dma_engine`

## Requirements
- R1: After reset all four channels are masked. The outputs hold_req, mem_rd, mem_wr, dack, tc and irq are low, and no request causes a bus acquisition until the channel is unmasked.
- R2: A write with reg_we high updates channel reg_ch on the next clock edge, according to reg_sel:
  - 0 sets base and working address.
  - 1 sets base and working count and re-arms a stopped channel.
  - 2 sets the mode word: bit0 = 1 selects device-to-memory (mem_wr), bit1 = 1 selects a decrementing address, bit2 enables autoinitialize, and bits[4:3] select the service kind (0 single, 1 block, 2 demand).
  - 3 sets the mask to reg_wdata[0].
  - 4 with reg_wdata[0] = 1 sets the software request.
  - 5 clears the interrupt flag.
- R3: hold_req rises the cycle after an eligible request appears. No strobe, address or dack is driven in a cycle without hold_ack. The first strobe follows the first cycle in which hold_ack is seen high. hold_req falls in the cycle right after the last strobe of a service.
- R4: Each strobe presents the working address. The next byte of the channel uses that address plus one, or minus one when mode bit1 is set, modulo 2^16.
- R5: During a strobe exactly one dack bit is high: the served channel's. mem_wr is high for device-to-memory and mem_rd otherwise, never both at once.
- R6: A programmed count c yields c+1 bytes before terminal count. tc is high only during the last of them, the byte on which the count wraps from 0 to FFFFh.
- R7: In single mode each bus acquisition moves exactly one byte, and the bus is released after it.
- R8: In block mode bytes are moved on consecutive clocks under one acquisition until terminal count. When eop_in is high during a strobe, that byte is the last one. The channel stays armed after an eop stop and resumes at the next address and count.
- R9: Demand mode acts like block mode and also ends the service after a byte during which the channel's request is low. Such a stop raises no interrupt, and the channel resumes where it stopped.
- R10: When several eligible channels request together, the lowest-numbered channel is served first.
- R11: A masked channel, or one that reached terminal count without autoinitialize, ignores both its request line and its software request until it is unmasked or its count is rewritten.
- R12: With autoinitialize set, terminal count reloads the working address and count from the base values, and the channel stays armed.
- R13: A service that ends on terminal count or on eop_in sets the channel's interrupt flag. irq is high while any flag is set, and a select-5 write clears it.
- R14: The software request bit is cleared when a service of that channel ends. A block service started by software therefore does not restart by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_ch | input | 2 | Channel addressed by the write |
| reg_sel | input | 3 | Field select of the write |
| reg_wdata | input | 16 | Write data |
| dreq | input | 4 | Device request lines, one per channel |
| eop_in | input | 1 | External end-of-process, sampled during strobes |
| hold_ack | input | 1 | Bus grant from the system arbiter |
| hold_req | output | 1 | Bus hold request |
| bus_addr | output | 16 | Memory address, zero outside strobes |
| mem_rd | output | 1 | Memory read strobe (memory-to-device) |
| mem_wr | output | 1 | Memory write strobe (device-to-memory) |
| dack | output | 4 | One-hot acknowledge to the served device |
| tc | output | 1 | Terminal count, high during the final byte |
| irq | output | 1 | OR of the channel interrupt flags |

## Verification
The assertions take for granted that the arbiter raises hold_ack only while hold_req is high and keeps it high until hold_req falls. They also assume that a channel's registers are not written while that channel is being served. The bench arbiter grants after a delay of zero to two cycles and drops the grant one cycle after the request falls. Every register write is issued only while the bus is quiet. Requests, eop pulses and request drops are driven half a cycle away from the clock edge, so the byte at which a service ends is fixed.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XK_SINGLE = 2'd0,
    XK_BLOCK  = 2'd1,
    XK_DEMAND = 2'd2,
    XK_RSVD   = 2'd3
  } xfer_kind_e;

  // Mode word, low five bits of the mode write
  typedef struct packed {
    xfer_kind_e kind;       // [4:3]
    logic       auto_init;  // [2]
    logic       addr_dec;   // [1]
    logic       to_mem;     // [0]
  } chan_mode_t;

  localparam logic [2:0] SEL_ADDR   = 3'd0;
  localparam logic [2:0] SEL_COUNT  = 3'd1;
  localparam logic [2:0] SEL_MODE   = 3'd2;
  localparam logic [2:0] SEL_MASK   = 3'd3;
  localparam logic [2:0] SEL_SWREQ  = 3'd4;
  localparam logic [2:0] SEL_IRQCLR = 3'd5;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          dreq,
  input  logic          step,
  input  logic          finish,
  input  logic          notify,
  output logic [AW-1:0] addr,
  output logic          cnt_zero,
  output chan_mode_t    mode,
  output logic          want,
  output logic          irq_pend
);
  localparam int MW = $bits(chan_mode_t);

  logic [AW-1:0] base_a, cur_a;
  logic [CW-1:0] base_c, cur_c;
  logic          mask, swreq, done;
  logic          unused_hi;

  assign unused_hi = ^wr_data[DW-1:MW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a   <= '0;
      cur_a    <= '0;
      base_c   <= '0;
      cur_c    <= '0;
      mode     <= '0;
      mask     <= 1'b1;
      swreq    <= 1'b0;
      done     <= 1'b0;
      irq_pend <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ADDR:   begin base_a <= wr_data[AW-1:0]; cur_a <= wr_data[AW-1:0]; end
        SEL_COUNT:  begin base_c <= wr_data[CW-1:0]; cur_c <= wr_data[CW-1:0]; done <= 1'b0; end
        SEL_MODE:   mode <= chan_mode_t'(wr_data[MW-1:0]);
        SEL_MASK:   mask <= wr_data[0];
        SEL_SWREQ:  if (wr_data[0]) swreq <= 1'b1;
        SEL_IRQCLR: irq_pend <= 1'b0;
        default: ;
      endcase
    end else begin
      if (step) begin
        if (cur_c == '0 && mode.auto_init) begin
          cur_a <= base_a;
          cur_c <= base_c;
        end else begin
          cur_c <= cur_c - 1'b1;
          cur_a <= mode.addr_dec ? cur_a - 1'b1 : cur_a + 1'b1;
          if (cur_c == '0) done <= 1'b1;
        end
      end
      if (finish) swreq <= 1'b0;
      if (finish && notify) irq_pend <= 1'b1;
    end
  end

  assign addr     = cur_a;
  assign cnt_zero = (cur_c == '0);
  assign want     = (dreq | swreq) & ~mask & ~done;

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && cur_c != '0) |=> (cur_c == $past(cur_c) - 1'b1));

  p_done_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && cur_c == '0 && !mode.auto_init) |=> !want);

  p_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && cur_c == '0 && mode.auto_init) |=> (cur_c == base_c && cur_a == base_a));
endmodule

// File: rtl/dma_prio.sv
module dma_prio #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> pick[0]);

  p_pick_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($onehot(pick) && (pick & req) != '0));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pick,
  input  logic         hold_ack,
  input  logic         eop_in,
  input  logic         act_zero,
  input  xfer_kind_e   act_kind,
  input  logic         act_want,
  output logic         hold_req,
  output logic [N-1:0] grant,
  output logic         xfer,
  output logic         finish,
  output logic         notify
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER} seq_state_e;
  seq_state_e state;
  logic       term;

  always_comb begin
    case (act_kind)
      XK_BLOCK:  term = act_zero | eop_in;
      XK_DEMAND: term = act_zero | eop_in | ~act_want;
      default:   term = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      grant <= '0;
    end else begin
      case (state)
        S_IDLE: if (|pick) begin grant <= pick; state <= S_WAIT; end
        S_WAIT: if (hold_ack) state <= S_XFER;
        S_XFER: if (term) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign xfer     = (state == S_XFER);
  assign hold_req = (state != S_IDLE);
  assign finish   = xfer & term;
  assign notify   = finish & (act_zero | eop_in);

  p_ack_before_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> hold_ack);

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !hold_req);

  p_single_one_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && act_kind == XK_SINGLE) |=> !xfer);

  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |-> $onehot(grant));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int CHW = $clog2(N),
  localparam int DW  = (AW > CW) ? AW : CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [CHW-1:0] reg_ch,
  input  logic [2:0]     reg_sel,
  input  logic [DW-1:0]  reg_wdata,
  input  logic [N-1:0]   dreq,
  input  logic           eop_in,
  input  logic           hold_ack,
  output logic           hold_req,
  output logic [AW-1:0]  bus_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [N-1:0]   dack,
  output logic           tc,
  output logic           irq
);
  localparam int MW = $bits(chan_mode_t);

  logic [AW-1:0] addr_v [N];
  logic [MW-1:0] mode_v [N];
  logic [N-1:0]  zero_v, want_v, irq_v, pick, grant;
  logic          xfer, finish, notify;
  logic [AW-1:0] act_addr;
  logic [MW-1:0] act_bits;
  chan_mode_t    act_mode;
  logic          act_zero, act_want;

  for (genvar g = 0; g < N; g++) begin : g_ch
    chan_mode_t m;
    dma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we && reg_ch == CHW'(g)),
      .wr_sel   (reg_sel),
      .wr_data  (reg_wdata),
      .dreq     (dreq[g]),
      .step     (xfer && grant[g]),
      .finish   (finish && grant[g]),
      .notify   (notify),
      .addr     (addr_v[g]),
      .cnt_zero (zero_v[g]),
      .mode     (m),
      .want     (want_v[g]),
      .irq_pend (irq_v[g])
    );
    assign mode_v[g] = m;
  end

  dma_prio #(.N(N)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (want_v),
    .pick  (pick)
  );

  always_comb begin
    act_addr = '0;
    act_bits = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        act_addr = act_addr | addr_v[i];
        act_bits = act_bits | mode_v[i];
      end
    end
  end
  assign act_mode = chan_mode_t'(act_bits);
  assign act_zero = |(zero_v & grant);
  assign act_want = |(want_v & grant);

  dma_seq #(.N(N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pick     (pick),
    .hold_ack (hold_ack),
    .eop_in   (eop_in),
    .act_zero (act_zero),
    .act_kind (act_mode.kind),
    .act_want (act_want),
    .hold_req (hold_req),
    .grant    (grant),
    .xfer     (xfer),
    .finish   (finish),
    .notify   (notify)
  );

  assign bus_addr = xfer ? act_addr : '0;
  assign mem_wr   = xfer & act_mode.to_mem;
  assign mem_rd   = xfer & ~act_mode.to_mem;
  assign dack     = xfer ? grant : '0;
  assign tc       = xfer & act_zero;
  assign irq      = |irq_v;

  p_dack_matches_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> $onehot(dack));

  p_quiet_without_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req |-> (dack == '0 && !mem_rd && !mem_wr));
endmodule

// File: tb/test_dma_engine.sv
module test_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_ch;
  logic [2:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [3:0]  dreq;
  logic        eop_in;
  logic        hold_ack;
  logic        hold_req;
  logic [15:0] bus_addr;
  logic        mem_rd, mem_wr;
  logic [3:0]  dack;
  logic        tc, irq;

  always #10 clk = ~clk;

  dma_engine i_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .eop_in(eop_in), .hold_ack(hold_ack),
    .hold_req(hold_req), .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .dack(dack), .tc(tc), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;

  // Arbiter model: grant after ack_delay cycles, release one cycle after request falls
  int ack_delay = 0;
  int ack_cnt;
  always @(posedge clk) begin
    if (!rst_n || !hold_req) begin
      hold_ack <= 1'b0;
      ack_cnt  <= 0;
    end else if (!hold_ack) begin
      if (ack_cnt >= ack_delay) hold_ack <= 1'b1;
      else ack_cnt <= ack_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int chan_of(input logic [3:0] d);
    int r;
    r = -1;
    for (int i = 0; i < 4; i++) if (d == (4'b1 << i)) r = i;
    return r;
  endfunction

  // Strobe monitor
  int   n_log, n_acq;
  int   lg_ch [64];
  int   lg_addr [64];
  bit   lg_wr [64];
  bit   lg_tc [64];
  logic prev_req = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_req && !prev_req) n_acq++;
      if (mem_rd || mem_wr) begin
        if (n_log < 64) begin
          lg_ch[n_log]   = chan_of(dack);
          lg_addr[n_log] = int'(bus_addr);
          lg_wr[n_log]   = mem_wr;
          lg_tc[n_log]   = tc;
        end
        n_log++;
        chk(hold_ack === 1'b1, "R3", "strobe without hold_ack", int'(hold_ack), 1);
        chk(!(mem_rd && mem_wr), "R5", "both strobes", 1, 0);
      end
    end
    prev_req = hold_req;
  end

  task automatic clr_log();
    @(negedge clk); #1;
    n_log = 0;
    n_acq = 0;
  endtask

  task automatic wr(input int ch, input int sel, input int data);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 2'(ch); reg_sel = 3'(sel); reg_wdata = 16'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic settle();
    int q;
    q = 0;
    while (q < 8) begin
      @(negedge clk);
      if (hold_req) q = 0; else q++;
    end
  endtask

  function automatic int mode_word(input int kind, input int ai, input int dec, input int to_mem);
    return (kind << 3) | (ai << 2) | (dec << 1) | to_mem;
  endfunction

  task automatic prog(input int ch, input int addr, input int cnt, input int mw);
    wr(ch, 0, addr);
    wr(ch, 1, cnt);
    wr(ch, 2, mw);
    wr(ch, 5, 0);
    wr(ch, 3, 0);
  endtask

  function automatic int step_addr(input int base, input int k, input int dec);
    return dec ? ((base - k) & 16'hFFFF) : ((base + k) & 16'hFFFF);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_ch = '0; reg_sel = '0; reg_wdata = '0;
    dreq = '0; eop_in = 1'b0; n_log = 0; n_acq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1: reset state, all channels masked
    chk(!hold_req && !mem_rd && !mem_wr && dack == 4'b0 && !tc && !irq, "R1", "outputs after reset",
        int'({hold_req, mem_rd, mem_wr, tc, irq}), 0);
    clr_log();
    dreq = 4'hF;
    repeat (20) @(negedge clk);
    #1 chk(n_acq == 0, "R1", "acquisitions while masked", n_acq, 0);
    dreq = 4'h0;

    // Sweep: channel x kind x direction x address step x count
    for (int ch = 0; ch < 4; ch++)
      for (int kind = 0; kind < 3; kind++)
        for (int dir = 0; dir < 2; dir++)
          for (int dec = 0; dec < 2; dec++)
            for (int c = 0; c < 4; c++) begin
              int base, ok_a, ok_w, ok_c, ok_t, exp_acq;
              bit use_sw;
              base = 16'h1080 + ch * 16'h100;
              ack_delay = (c + ch) % 3;
              prog(ch, base, c, mode_word(kind, 0, dec, dir));
              clr_log();
              use_sw = (kind == 1) && (dir == 1);
              if (use_sw) wr(ch, 4, 1);
              else dreq[ch] = 1'b1;
              settle();
              dreq = 4'h0;
              ok_a = 1; ok_w = 1; ok_c = 1; ok_t = 1;
              for (int k = 0; k < c + 1 && k < n_log; k++) begin
                if (lg_addr[k] != step_addr(base, k, dec)) ok_a = 0;
                if (lg_wr[k] != bit'(dir)) ok_w = 0;
                if (lg_ch[k] != ch) ok_c = 0;
                if (lg_tc[k] != (k == c)) ok_t = 0;
              end
              exp_acq = (kind == 0) ? c + 1 : 1;
              chk(n_log == c + 1, "R6", "byte count", n_log, c + 1);
              chk(ok_a == 1, "R4", "address sequence", lg_addr[0], base);
              chk(ok_w == 1, "R5", "strobe direction", int'(lg_wr[0]), dir);
              chk(ok_c == 1, "R5", "dack channel", lg_ch[0], ch);
              chk(ok_t == 1, "R6", "tc only on last byte", int'(lg_tc[c]), 1);
              if (kind == 0) chk(n_acq == exp_acq, "R7", "single acquisitions", n_acq, exp_acq);
              else chk(n_acq == exp_acq, "R8", "block/demand acquisitions", n_acq, exp_acq);
              chk(irq == 1'b1, "R13", "irq after tc", int'(irq), 1);
              wr(ch, 5, 0);
            end
    ack_delay = 1;
    @(negedge clk); #1;
    chk(irq == 1'b0, "R13", "irq cleared", int'(irq), 0);

    // R10: fixed priority for every pair
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++) begin
        prog(a, a * 16, 0, mode_word(0, 0, 0, 1));
        prog(b, b * 16, 0, mode_word(0, 0, 0, 1));
        clr_log();
        dreq = (4'b1 << a) | (4'b1 << b);
        settle();
        dreq = 4'h0;
        chk(n_log == 2 && lg_ch[0] == a && lg_ch[1] == b, "R10", "service order (first channel)",
            lg_ch[0], a);
        wr(a, 5, 0);
        wr(b, 5, 0);
      end

    // R9: demand stop on request drop, then resume
    prog(2, 16'h0300, 9, mode_word(2, 0, 0, 1));
    clr_log();
    dreq[2] = 1'b1;
    while (n_log < 3) begin @(negedge clk); #1; end
    dreq[2] = 1'b0;
    settle();
    chk(n_log == 3, "R9", "bytes before request drop", n_log, 3);
    chk(irq == 1'b0, "R9", "no irq on demand stop", int'(irq), 0);
    chk(lg_tc[2] == 1'b0, "R9", "no tc on demand stop", int'(lg_tc[2]), 0);
    clr_log();
    dreq[2] = 1'b1;
    settle();
    dreq[2] = 1'b0;
    chk(n_log == 7 && lg_addr[0] == 16'h0303, "R9", "resume address", lg_addr[0], 16'h0303);
    chk(lg_addr[6] == 16'h0309 && lg_tc[6], "R6", "final byte after resume", lg_addr[6], 16'h0309);
    chk(irq == 1'b1, "R13", "irq after demand tc", int'(irq), 1);
    wr(2, 5, 0);

    // R8/R14: block by software request stopped by eop, then resumed
    prog(3, 16'h0400, 20, mode_word(1, 0, 1, 0));
    clr_log();
    wr(3, 4, 1);
    while (n_log < 2) begin @(negedge clk); #1; end
    eop_in = 1'b1;
    @(posedge clk); #1;
    eop_in = 1'b0;
    settle();
    chk(n_log == 2, "R8", "bytes before eop", n_log, 2);
    chk(n_log == 2, "R14", "software request not re-served", n_log, 2);
    chk(irq == 1'b1, "R13", "irq after eop", int'(irq), 1);
    chk(lg_wr[0] == 1'b0, "R5", "memory read strobe", int'(lg_wr[0]), 0);
    wr(3, 5, 0);
    @(negedge clk); #1;
    chk(irq == 1'b0, "R13", "irq clear after eop", int'(irq), 0);
    clr_log();
    wr(3, 4, 1);
    settle();
    chk(n_log == 19, "R8", "bytes after eop resume", n_log, 19);
    chk(lg_addr[0] == 16'h03FE && lg_addr[18] == 16'h03EC, "R4", "decrement after resume",
        lg_addr[18], 16'h03EC);
    wr(3, 5, 0);

    // R11: mask and terminal-count lockout
    prog(1, 16'h0500, 0, mode_word(0, 0, 0, 1));
    wr(1, 3, 1);
    clr_log();
    dreq[1] = 1'b1;
    repeat (20) @(negedge clk);
    #1 chk(n_acq == 0 && n_log == 0, "R11", "masked channel acquisitions", n_acq, 0);
    wr(1, 3, 0);
    settle();
    chk(n_log == 1 && lg_addr[0] == 16'h0500, "R11", "served after unmask", n_log, 1);
    clr_log();
    repeat (20) @(negedge clk);
    wr(1, 4, 1);
    repeat (20) @(negedge clk);
    #1 chk(n_log == 0, "R11", "requests ignored after tc", n_log, 0);
    dreq[1] = 1'b0;
    wr(1, 5, 0);
    clr_log();
    wr(1, 1, 0);
    wr(1, 4, 1);
    settle();
    chk(n_log == 1 && lg_addr[0] == 16'h0501, "R2", "count rewrite re-arms", lg_addr[0], 16'h0501);
    wr(1, 5, 0);

    // R12: autoinitialize reload
    prog(0, 16'h0050, 1, mode_word(1, 1, 0, 1));
    clr_log();
    wr(0, 4, 1);
    settle();
    chk(n_log == 2 && lg_addr[1] == 16'h0051 && lg_tc[1], "R12", "first pass", lg_addr[1], 16'h0051);
    clr_log();
    wr(0, 4, 1);
    settle();
    chk(n_log == 2 && lg_addr[0] == 16'h0050 && lg_addr[1] == 16'h0051, "R12", "reloaded pass",
        lg_addr[0], 16'h0050);
    wr(0, 5, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule